// File: doc/BRIEF.md
# Piezo Motor Pulse-Train Sequencer

The sequencer produces a finite burst of two-phase switching pulses for a piezo motor. Software writes a period register and a pulse register through a single-word write port. The period register gives the switching period in input clock cycles. Its top bit selects a doubler that halves the number of clock cycles per period, so a clock at half the rate gives the same switching frequency. The pulse register holds the number of pulses in the burst and a direction bit.

While a burst runs, one phase output is high for the first half of every period and the other for the second half. The direction bit chooses which phase leads. A busy flag covers the whole burst. Writing a zero pulse count, or pulling the active-low power-down input low, stops the burst at once and drives both phases low. A new period value is applied only at a period boundary, so no truncated pulse appears.

Top module: `piezo_burst_seq`

## Requirements
- R1: After reset, busy_o, phase_a_o and phase_b_o are low and the period register holds 111 with the doubler clear. A burst of one pulse written straight after reset therefore lasts 111 cycles.
- R2: When a pulse write with a non-zero count arrives while idle and pd_ni is high, busy_o is high from the next cycle for exactly N*P cycles and then goes low. N is the count and P is the effective period.
- R3: Address 0 selects the period register. Its bits [14:0] hold the period value. Address 1 selects the pulse register. Its bits [10:0] hold the count and bit 14 holds the direction.
- R4: When bit 15 of the period register is set, the effective period is the period value shifted right by one. Otherwise it is the period value itself.
- R5: An effective period below 2 is treated as 2.
- R6: With direction 0, phase_a_o is high for the first floor(P/2) cycles of each period and phase_b_o is high for the remaining cycles. The two phases are never high together.
- R7: With direction 1, the two phases swap roles.
- R8: A pulse write with a zero count stops a running burst. From the next cycle, busy_o and both phases are low.
- R9: While pd_ni is low, both phases are low in the same cycle. From the next cycle busy_o is low, and pulse writes do not start a burst.
- R10: A period write during a burst is applied from the next period boundary onward. The period in progress keeps its length.
- R11: A non-zero pulse write during a burst has no effect on its remaining count or its direction.
- R12: Whenever busy_o is low, both phase outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: period register, 1: pulse register |
| wr_data_i | input | 16 | Write data |
| phase_a_o | output | 1 | Phase A drive |
| phase_b_o | output | 1 | Phase B drive |
| busy_o | output | 1 | Burst in progress |

## Verification
The bench uses the default parameters: a 16-bit data word, an 11-bit count, the doubler at bit 15 and the direction at bit 14. The small widths are not needed because the period is a register value. Sweeping raw period values from 0 to 13 with and without the doubler covers the clamp, odd and even half-period splits, and both directions. Each burst has one to three pulses, which keeps every burst short enough to check cycle by cycle against an arithmetic model. Directed bursts add a mid-burst period change, an ignored pulse write, a zero-count abort and a power-down abort.

// File: rtl/piezo_pkg.sv
package piezo_pkg;
  typedef enum logic {
    REG_PERIOD = 1'b0,
    REG_PULSE  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/piezo_regs.sv
module piezo_regs #(
  parameter int DATA_W  = 16,
  parameter int DBL_BIT = 15,
  parameter int PER_W   = 15,
  parameter int DEF_PER = 111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              per_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PER_W-1:0]  eff_per_o
);
  logic [PER_W-1:0] per_q;
  logic             dbl_q;
  logic [PER_W-1:0] scaled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= PER_W'(DEF_PER);
      dbl_q <= 1'b0;
    end else if (per_we_i) begin
      per_q <= wr_data_i[PER_W-1:0];
      dbl_q <= wr_data_i[DBL_BIT];
    end
  end

  // doubler: same switching rate from half the clock
  assign scaled    = dbl_q ? (per_q >> 1) : per_q;
  assign eff_per_o = (scaled < PER_W'(2)) ? PER_W'(2) : scaled;
endmodule

// File: rtl/piezo_period_gen.sv
module piezo_period_gen #(
  parameter int PER_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic             run_i,
  input  logic [PER_W-1:0] per_i,
  output logic             last_o,
  output logic             first_half_o
);
  logic [PER_W-1:0] pos_q;
  logic [PER_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      cur_q <= PER_W'(2);
    end else if (reload_i) begin
      pos_q <= '0;
      cur_q <= per_i;
    end else if (run_i) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign last_o       = (pos_q == cur_q - 1'b1);
  assign first_half_o = (pos_q < (cur_q >> 1));
endmodule

// File: rtl/piezo_burst_ctl.sv
module piezo_burst_ctl #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_i,
  output logic             busy_o,
  output logic             dir_o,
  output logic             final_o
);
  logic [CNT_W-1:0] rem_q;

  assign final_o = (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      dir_o  <= 1'b0;
      rem_q  <= '0;
    end else if (abort_i) begin
      busy_o <= 1'b0;
      rem_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      dir_o  <= dir_i;
      rem_q  <= cnt_i;
    end else if (busy_o && last_i) begin
      if (final_o) busy_o <= 1'b0;
      rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/piezo_burst_seq.sv
module piezo_burst_seq #(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 11,
  parameter int DIR_BIT = 14,
  parameter int DBL_BIT = 15,
  parameter int DEF_PER = 111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              phase_a_o,
  output logic              phase_b_o,
  output logic              busy_o
);
  import piezo_pkg::*;

  localparam int PER_W = DBL_BIT;

  logic             per_we, pulse_we, cnt_zero;
  logic             start, abort, reload;
  logic             last, first_half, fin, dir;
  logic [PER_W-1:0] eff_per;
  logic [CNT_W-1:0] cnt;
  logic             lead;

  assign cnt      = wr_data_i[CNT_W-1:0];
  assign cnt_zero = (cnt == '0);
  assign per_we   = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_PERIOD);
  assign pulse_we = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_PULSE);
  assign abort    = !pd_ni || (pulse_we && cnt_zero);
  assign start    = pulse_we && !cnt_zero && !busy_o && pd_ni;
  assign reload   = start || (busy_o && last && !fin && !abort);

  piezo_regs #(
    .DATA_W (DATA_W),
    .DBL_BIT(DBL_BIT),
    .PER_W  (PER_W),
    .DEF_PER(DEF_PER)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .per_we_i (per_we),
    .wr_data_i(wr_data_i),
    .eff_per_o(eff_per)
  );

  piezo_period_gen #(.PER_W(PER_W)) u_pgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reload_i    (reload),
    .run_i       (busy_o),
    .per_i       (eff_per),
    .last_o      (last),
    .first_half_o(first_half)
  );

  piezo_burst_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .abort_i(abort),
    .last_i (last),
    .cnt_i  (cnt),
    .dir_i  (wr_data_i[DIR_BIT]),
    .busy_o (busy_o),
    .dir_o  (dir),
    .final_o(fin)
  );

  // power-down gates the drivers combinationally
  assign lead      = dir ? !first_half : first_half;
  assign phase_a_o = busy_o && pd_ni && lead;
  assign phase_b_o = busy_o && pd_ni && !lead;
endmodule

// File: rtl/piezo_burst_seq_chk.sv
module piezo_burst_seq_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pd_ni,
  input logic              wr_en_i,
  input logic              wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              phase_a_o,
  input logic              phase_b_o,
  input logic              busy_o
);
  logic zero_wr, go_wr;
  assign zero_wr = wr_en_i && wr_addr_i && (wr_data_i[CNT_W-1:0] == '0);
  assign go_wr   = wr_en_i && wr_addr_i && (wr_data_i[CNT_W-1:0] != '0);

  assert_phase_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_a_o && phase_b_o));

  assert_idle_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!phase_a_o && !phase_b_o));

  assert_zero_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_wr |=> !busy_o);

  assert_pd_outputs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |-> (!phase_a_o && !phase_b_o));

  assert_pd_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !busy_o);

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr && pd_ni && !busy_o) |=> busy_o);
endmodule

bind piezo_burst_seq piezo_burst_seq_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pd_ni    (pd_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .phase_a_o(phase_a_o),
  .phase_b_o(phase_b_o),
  .busy_o   (busy_o)
);

// File: tb/tb_piezo_burst_seq.sv
module tb_piezo_burst_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pd_ni = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        wr_addr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        phase_a_o, phase_b_o, busy_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  piezo_burst_seq dut (.*);

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual={busy,a,b}=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input int raw, input bit dbl);
    int e;
    e = dbl ? (raw >> 1) : raw;
    return (e < 2) ? 2 : e;
  endfunction

  // expected {busy,a,b} in cycle k; first pulse period p0, later ones p1
  function automatic logic [2:0] expf(input int k, input int p0, input int p1,
                                      input int n, input bit dir);
    int pi, pos, per;
    bit fh, a;
    if (k < p0) begin pi = 0; pos = k; per = p0; end
    else begin pi = 1 + (k - p0) / p1; pos = (k - p0) % p1; per = p1; end
    if (pi >= n) return 3'b000;
    fh = (pos < per / 2);
    a  = dir ? !fh : fh;
    return {1'b1, a, !a};
  endfunction

  task automatic wr(input bit addr, input logic [15:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = data;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  // ev_t: 0 none, 1 period write, 2 nonzero pulse write, 3 zero write, 4 power-down
  task automatic run(input int praw, input bit dbl, input int n, input bit dir,
                     input int ev_k, input int ev_t, input logic [15:0] ev_val,
                     input string req);
    int p0, p1, stop;
    logic [2:0] e;
    p0 = eff(praw, dbl);
    p1 = (ev_t == 1) ? eff(int'(ev_val[14:0]), ev_val[15]) : p0;
    stop = (ev_t >= 3) ? ev_k + 1 : p0 + (n - 1) * p1;
    wr(1'b0, {dbl, 15'(praw)});
    wr(1'b1, {1'b0, dir, 3'b000, 11'(n)});
    for (int k = 0; k <= stop; k++) begin
      @(negedge clk_i);
      wr_en_i = 1'b0;
      e = (ev_t >= 3 && k > ev_k) ? 3'b000 : expf(k, p0, p1, n, dir);
      check({busy_o, phase_a_o, phase_b_o}, e, req);
      if (k == ev_k) begin
        case (ev_t)
          1: begin wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = ev_val; end
          2: begin wr_en_i = 1'b1; wr_addr_i = 1'b1; wr_data_i = ev_val; end
          3: begin wr_en_i = 1'b1; wr_addr_i = 1'b1; wr_data_i = 16'h0000; end
          4: begin
            pd_ni = 1'b0;
            #1 check({1'b0, phase_a_o, phase_b_o}, 3'b000, "R9 same-cycle");
          end
          default: ;
        endcase
      end
    end
    if (ev_t == 4) begin
      wr(1'b1, 16'h0005);
      @(negedge clk_i);
      check({busy_o, phase_a_o, phase_b_o}, 3'b000, "R9 write ignored");
      pd_ni = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] e;
    repeat (3) @(negedge clk_i);
    check({busy_o, phase_a_o, phase_b_o}, 3'b000, "R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({busy_o, phase_a_o, phase_b_o}, 3'b000, "R1 after reset");

    // R1: default period of 111 used without a period write
    wr(1'b1, 16'h0001);
    for (int k = 0; k <= 111; k++) begin
      @(negedge clk_i);
      e = expf(k, 111, 111, 1, 1'b0);
      check({busy_o, phase_a_o, phase_b_o}, e, "R1 default period");
    end

    // R2 R3 R4 R5 R6 R7 R12: sweep of raw period, doubler, count, direction
    for (int praw = 0; praw < 14; praw++)
      for (int dbl = 0; dbl < 2; dbl++)
        for (int n = 1; n <= 3; n++)
          for (int dir = 0; dir < 2; dir++)
            run(praw, dbl[0], n, dir[0], -1, 0, 16'h0,
                dbl != 0 ? "R4 doubler" :
                praw < 2 ? "R5 clamp" :
                dir != 0 ? "R7 reverse" : "R2 R3 R6 forward");

    // R10: period change mid-burst applied at the next boundary
    run(4, 1'b0, 3, 1'b0, 1, 1, 16'h0006, "R10 period change");
    run(10, 1'b1, 3, 1'b1, 0, 1, 16'h0007, "R10 doubler change");
    // R11: nonzero pulse write during burst ignored
    run(5, 1'b0, 2, 1'b0, 2, 2, 16'h4009, "R11 ignored write");
    // R8: zero write aborts
    run(4, 1'b0, 5, 1'b0, 6, 3, 16'h0, "R8 zero abort");
    run(7, 1'b0, 3, 1'b1, 0, 3, 16'h0, "R8 zero abort early");
    // R9: power-down aborts
    run(4, 1'b0, 3, 1'b0, 2, 4, 16'h0, "R9 power-down");
    // R2: restart after power-down release
    run(3, 1'b0, 2, 1'b0, -1, 0, 16'h0, "R2 restart");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule